// File: doc/BRIEF.md
# PCI Initiator Local-Bus Strobe Generator

This block lets a simple burst-style local bus follow the PCI transactions that the device starts as bus initiator. It samples the PCI FRAME#, IRDY# and TRDY# lines on each rising clock edge and drives three registered, active-low sideband strobes. The address strobe marks the start of each transaction. The data strobe marks each completed data phase. The burst-last strobe marks the final data phase, from the point where FRAME# is released until IRDY# is released.

The strobes only mean anything while the device owns the bus. While the initiator-active flag is low, all three stay high. The data strobe behaves the same for reads and writes, so the block needs no transfer-direction input. A synchronous reset returns every strobe and the internal FRAME# history to idle.

Top module: `pci_lbus_strobe`

## Requirements
- R1: Every strobe is a register output. A change on the inputs between rising edges leaves the strobes unchanged until the next rising clock edge.
- R2: While `init_act` is sampled low, all three strobes are high after that edge, whatever the PCI lines do.
- R3: `as_n` goes low after the edge at which `frame_n` is sampled low, having been sampled high at the edge before. It returns high after the following edge, even if `frame_n` stays low.
- R4: `ds_n` is low after any edge at which `irdy_n` and `trdy_n` are both sampled low, and high after any edge at which either is high. This holds for read and write transfers alike.
- R5: `blast_n` goes low after the edge at which `frame_n` is sampled high, having been sampled low at the previous edge, while `irdy_n` is sampled low. This includes a single-data-phase transfer.
- R6: `blast_n` returns high after the first edge at which `irdy_n` is sampled high. Between its set and that edge it holds low across wait states.
- R7: When `rst` is sampled high, all strobes are high after that edge and the FRAME# history reads as idle (high).
- R8: A new transaction whose FRAME# falls one cycle after the previous transaction's idle cycle produces a fresh one-cycle address strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| init_act | input | 1 | High while the device is bus initiator |
| frame_n | input | 1 | PCI FRAME#, active low |
| irdy_n | input | 1 | PCI IRDY#, active low |
| trdy_n | input | 1 | PCI TRDY#, active low |
| as_n | output | 1 | Local address strobe, active low |
| ds_n | output | 1 | Local data strobe, active low |
| blast_n | output | 1 | Local burst-last strobe, active low |

## Verification
The assertions check five rules on every cycle: the address strobe never lasts more than one cycle, a completed handshake always yields a data strobe, a released IRDY# always releases burst-last, and both the idle flag and reset force all strobes high. Only the bench scenarios can show the sequences the strobes must follow: a single-phase read, a burst write with a wait state, back-to-back transactions, loss of bus ownership in mid-burst, and a reset during the burst-last window. The bench also shows that the strobes ignore input changes between clock edges.

// File: rtl/pci_lbus_strobe.sv
module pci_lbus_strobe (
  input  logic clk,
  input  logic rst,
  input  logic init_act,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n,
  output logic as_n,
  output logic ds_n,
  output logic blast_n
);

  logic frame_q;
  logic frame_fall;
  logic frame_rise;
  logic xfer_done;

  assign frame_fall = ~frame_n & frame_q;
  assign frame_rise = frame_n & ~frame_q;
  assign xfer_done  = ~irdy_n & ~trdy_n;

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b1;
    else     frame_q <= frame_n;
  end

  always_ff @(posedge clk) begin
    if (rst || !init_act) begin
      as_n    <= 1'b1;
      ds_n    <= 1'b1;
      blast_n <= 1'b1;
    end else begin
      as_n <= ~frame_fall;
      ds_n <= ~xfer_done;
      if (frame_rise && !irdy_n) blast_n <= 1'b0;
      else if (irdy_n)           blast_n <= 1'b1;
    end
  end

  assert_as_single_R3: assert property (@(posedge clk) disable iff (rst)
    !as_n |=> as_n);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !init_act |=> (as_n && ds_n && blast_n));

  assert_ds_on_done_R4: assert property (@(posedge clk) disable iff (rst)
    (init_act && !irdy_n && !trdy_n) |=> !ds_n);

  assert_blast_release_R6: assert property (@(posedge clk) disable iff (rst)
    irdy_n |=> blast_n);

  assert_reset_idle_R7: assert property (@(posedge clk)
    rst |=> (as_n && ds_n && blast_n));

endmodule

// File: tb/pci_lbus_strobe_bench.sv
`timescale 1ns/1ps
module pci_lbus_strobe_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_act = 1'b0;
  logic frame_n = 1'b1;
  logic irdy_n = 1'b1;
  logic trdy_n = 1'b1;
  logic as_n, ds_n, blast_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_lbus_strobe u_pci_lbus_strobe (
    .clk(clk), .rst(rst), .init_act(init_act),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .as_n(as_n), .ds_n(ds_n), .blast_n(blast_n)
  );

  task automatic chk(input logic ea, input logic ed, input logic eb, input string req);
    checks++;
    if (as_n !== ea || ds_n !== ed || blast_n !== eb) begin
      errors++;
      $display("FAIL %s: as/ds/blast actual=%b%b%b expected=%b%b%b", req,
               as_n, ds_n, blast_n, ea, ed, eb);
    end
  endtask

  task automatic step(input logic f, input logic i, input logic t);
    @(negedge clk);
    frame_n = f; irdy_n = i; trdy_n = t;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1; init_act = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk(1, 1, 1, "R7");
    step(1'b1, 1'b1, 1'b1);
    rst = 1'b0;
    step(1'b1, 1'b1, 1'b1);
    chk(1, 1, 1, "R7");
  endtask

  task automatic t_single_read;
    step(1'b0, 1'b1, 1'b1); chk(0, 1, 1, "R3");
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0;
    #1 chk(0, 1, 1, "R1");
    @(posedge clk); #1; chk(1, 1, 0, "R5");
    step(1'b1, 1'b0, 1'b0); chk(1, 0, 0, "R4");
    step(1'b1, 1'b1, 1'b1); chk(1, 1, 1, "R6");
  endtask

  task automatic t_burst_write;
    step(1'b0, 1'b1, 1'b1); chk(0, 1, 1, "R3");
    step(1'b0, 1'b0, 1'b0); chk(1, 0, 1, "R4");
    step(1'b0, 1'b0, 1'b1); chk(1, 1, 1, "R4");
    step(1'b0, 1'b0, 1'b0); chk(1, 0, 1, "R3");
    step(1'b1, 1'b0, 1'b1); chk(1, 1, 0, "R5");
    step(1'b1, 1'b0, 1'b1); chk(1, 1, 0, "R6");
    step(1'b1, 1'b0, 1'b0); chk(1, 0, 0, "R6");
    step(1'b1, 1'b1, 1'b1); chk(1, 1, 1, "R6");
  endtask

  task automatic t_back_to_back;
    step(1'b0, 1'b1, 1'b1); chk(0, 1, 1, "R8");
    step(1'b1, 1'b0, 1'b0); chk(1, 0, 0, "R8");
    step(1'b0, 1'b1, 1'b1); chk(0, 1, 1, "R8");
    step(1'b1, 1'b0, 1'b0); chk(1, 0, 0, "R8");
    step(1'b1, 1'b1, 1'b1); chk(1, 1, 1, "R8");
  endtask

  task automatic t_not_initiator;
    init_act = 1'b0;
    step(1'b0, 1'b1, 1'b1); chk(1, 1, 1, "R2");
    step(1'b1, 1'b0, 1'b0); chk(1, 1, 1, "R2");
    step(1'b1, 1'b1, 1'b1); chk(1, 1, 1, "R2");
    init_act = 1'b1;
    step(1'b0, 1'b1, 1'b1); chk(0, 1, 1, "R3");
    step(1'b0, 1'b0, 1'b0); chk(1, 0, 1, "R4");
    init_act = 1'b0;
    step(1'b1, 1'b0, 1'b0); chk(1, 1, 1, "R2");
    init_act = 1'b1;
    step(1'b1, 1'b1, 1'b1); chk(1, 1, 1, "R2");
  endtask

  task automatic t_reset_mid;
    step(1'b0, 1'b1, 1'b1); chk(0, 1, 1, "R3");
    step(1'b1, 1'b0, 1'b1); chk(1, 1, 0, "R5");
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b0); chk(1, 1, 1, "R7");
    rst = 1'b0;
    step(1'b1, 1'b0, 1'b0); chk(1, 0, 1, "R7");
    step(1'b1, 1'b1, 1'b1); chk(1, 1, 1, "R7");
  endtask

  initial begin
    t_reset();
    t_single_read();
    t_burst_write();
    t_back_to_back();
    t_not_initiator();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule